// File: doc/BRIEF.md
# Endian-Configurable Host Register Front End

This block sits between a host processor bus and the small register file of a position-feedback interface core. The host reaches the registers either one byte at a time (an 8-bit bus, or a serial host link that always uses byte addressing) or one 16-bit word at a time on a parallel bus. Each host address is turned into an internal register index. The translation depends on two configuration inputs: a byte-order select and a bus-width select. In little-endian byte mode, each group of four control bytes appears reversed. The multi-byte position and velocity fields are each reversed as a whole.

Host writes are paced. A free-running 3-bit Gray-code phase counter steps once per clock, and the host can read it. A write reaches the register array only at the clock edge that closes the cycle in which the phase is 000. A write requested at any other time is held in a single pending slot until that edge. A later request replaces the held one. A host that keeps its write strobe high for eight clocks never needs to look at the phase. Reads need no pacing: they pass combinationally from the array through the same address translation.

Top module: `erf_host_front`

## Requirements
- R1: While reset is applied, the phase output reads 000 and every register reads zero. After reset, the phase steps once per clock through 000, 001, 011, 010, 110, 111, 101, 100 and then repeats, with exactly one bit changing per step.
- R2: The register array changes only at a clock edge at which the phase output was 000 just before the edge. A write requested in any other cycle leaves every register unchanged until that edge.
- R3: A write requested outside the commit slot is held as pending. A second request made before the commit replaces it, so only the last request of the window is written.
- R4: A write strobe held high for eight consecutive clocks is always committed, whatever the phase was when the strobe began.
- R5: In byte addressing, the byte address is {h_addr, h_bsel}. In big-endian order (cfg_little=0) the byte address is the register index. In little-endian order, addresses 00h to 0Fh reach index address XOR 03h. Defined indices are 00h, 01h, 03h to 0Bh, and 0Dh to 17h.
- R6: In little-endian byte addressing, addresses 10h to 17h reach the following indices: 10h to 14h, 11h to 13h, 12h to 12h, 13h to 11h, 17h to 10h (the five-byte position field, index 10h most significant), then 14h to 17h, 15h to 16h, 16h to 15h (the three-byte velocity field, index 15h most significant).
- R7: In word addressing (cfg_wide=1, cfg_serial=0), h_addr gives byte-address bits 6:1 and h_bsel is not used. In big-endian order, byte {h_addr,0} is on bits 15:8 and byte {h_addr,1} is on bits 7:0. In little-endian order, byte {h_addr,1} is on bits 15:8 and byte {h_addr,0} is on bits 7:0. Each byte address is then translated as in R5 and R6.
- R8: In word addressing, h_be[1] enables the write of the byte on bits 15:8 and h_be[0] enables the byte on bits 7:0. With both set, both bytes change at the same commit edge. A byte whose enable is 0 keeps its value.
- R9: With cfg_serial=1, byte addressing is used whatever cfg_wide is, and h_be has no effect.
- R10: A byte address that reaches index 02h, 0Ch or any index of 18h and above reads as zero, and writes to it change nothing.
- R11: Reads are combinational, in the same cycle as the address. In byte addressing, h_rdata[15:8] is zero and the byte is on h_rdata[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_little | input | 1 | Byte order select: 1 = little-endian, 0 = big-endian |
| cfg_wide | input | 1 | 1 = 16-bit word addressing on the parallel bus |
| cfg_serial | input | 1 | 1 = serial host in use; forces byte addressing |
| h_addr | input | WORD_ADDR_W | Host address, byte-address bits 6:1 |
| h_bsel | input | 1 | Byte select, byte-address bit 0 (byte addressing only) |
| h_wr | input | 1 | Write request, sampled every clock |
| h_wdata | input | 16 | Write data; byte addressing uses bits 7:0 |
| h_be | input | 2 | Byte-lane write enables for word addressing |
| h_rdata | output | 16 | Combinational read data |
| wr_phase | output | PHASE_W | Gray-coded write-window phase; 000 marks the commit slot |

## Verification
The assertions assume that the host inputs are synchronous to clk and settle between edges. Requests are sampled only at rising edges, so the commit-slot and pending-clear properties presume that no input changes right at an edge. The bench changes the configuration, address, data and strobe only on falling edges and reads combinational data a short time after a falling edge. It watches wr_phase to place a write in the commit slot, or in a chosen other cycle when testing pending replacement and long strobes. The configuration inputs are treated as quasi-static: the bench changes them only while no write is pending.

// File: rtl/erf_pkg.sv
package erf_pkg;

  // Width of one register and number of byte lanes on the wide bus
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LANES     = 2;

  // Internal register map: 24 byte indices, of which 02h and 0Ch are holes
  localparam int unsigned MAP_BYTES = 24;
  localparam int unsigned IDX_W     = $clog2(MAP_BYTES);
  localparam logic [(1 << IDX_W)-1:0] DEFINED_MASK = 32'h00FF_EFFB;

  // Start of the eight-byte motion field block (position + velocity)
  localparam int unsigned FIELD_BASE = 16;

  typedef struct packed {
    logic              en;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] data;
  } lane_wr_t;

endpackage

// File: rtl/erf_phase_pacer.sv
module erf_phase_pacer #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] phase,
  output logic         slot
);

  logic [W-1:0] bin_now;
  logic [W-1:0] bin_nxt;
  logic [W-1:0] gray_nxt;

  // Gray to binary, add one, back to Gray
  always_comb begin
    for (int i = 0; i < int'(W); i++) begin
      bin_now[i] = ^(phase >> i);
    end
    bin_nxt  = bin_now + 1'b1;
    gray_nxt = bin_nxt ^ (bin_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else begin
      phase <= gray_nxt;
    end
  end

  assign slot = (phase == '0);

endmodule

// File: rtl/erf_addr_xlate.sv
module erf_addr_xlate
  import erf_pkg::*;
#(
  parameter int unsigned BA_W = 7
) (
  input  logic [BA_W-1:0]  byte_addr,
  input  logic             little,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);

  localparam logic [BA_W-1:0] MAP_A      = BA_W'(MAP_BYTES);
  localparam logic [BA_W-4:0] FIELD_BLK  = (BA_W-3)'(FIELD_BASE >> 3);
  localparam logic [BA_W-1:0] FIELD_A    = BA_W'(FIELD_BASE);

  logic [BA_W-1:0] mapped;
  logic [2:0]      off;
  logic [2:0]      rev;

  always_comb begin
    off = byte_addr[2:0];
    // Little-endian motion block: offsets 0..3 -> position bytes 4..1,
    // 4..6 -> velocity reversed, 7 -> most significant position byte.
    if (off == 3'd7) begin
      rev = 3'd0;
    end else if (off < 3'd4) begin
      rev = 3'd4 - off;
    end else begin
      rev = 3'd3 - off;  // 11 - off in three bits
    end

    if (!little) begin
      mapped = byte_addr;
    end else if (byte_addr < FIELD_A) begin
      mapped = {byte_addr[BA_W-1:2], ~byte_addr[1:0]};
    end else if (byte_addr[BA_W-1:3] == FIELD_BLK) begin
      mapped = {byte_addr[BA_W-1:3], rev};
    end else begin
      mapped = byte_addr;
    end

    idx = mapped[IDX_W-1:0];
    hit = (mapped < MAP_A) && DEFINED_MASK[mapped[IDX_W-1:0]];
  end

endmodule

// File: rtl/erf_write_hold.sv
module erf_write_hold
  import erf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot,
  input  logic                  req,
  input  lane_wr_t [LANES-1:0]  req_lanes,
  output lane_wr_t [LANES-1:0]  commit_lanes,
  output logic                  pend_busy
);

  logic                 pend_q;
  logic                 pend_d;
  logic                 load_en;
  lane_wr_t [LANES-1:0] pend_lanes_q;

  always_comb begin
    pend_d       = pend_q;
    load_en      = 1'b0;
    commit_lanes = '0;
    if (slot) begin
      if (req) begin
        commit_lanes = req_lanes;
      end else if (pend_q) begin
        commit_lanes = pend_lanes_q;
      end
      pend_d = 1'b0;
    end else if (req) begin
      load_en = 1'b1;
      pend_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lanes_q <= '0;
    end else if (load_en) begin
      pend_lanes_q <= req_lanes;
    end
  end

  assign pend_busy = pend_q;

endmodule

// File: rtl/erf_byte_store.sv
module erf_byte_store
  import erf_pkg::*;
#(
  parameter int unsigned N = MAP_BYTES
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  lane_wr_t [LANES-1:0]              wr,
  input  logic [LANES-1:0][IDX_W-1:0]       rd_idx,
  output logic [LANES-1:0][BYTE_W-1:0]      rd_data,
  output logic [N*BYTE_W-1:0]               cells_flat
);

  logic [N-1:0][BYTE_W-1:0] cells;

  for (genvar g = 0; g < int'(N); g++) begin : g_cell
    if (DEFINED_MASK[g]) begin : g_reg
      logic              we;
      logic [BYTE_W-1:0] nd;
      always_comb begin
        we = 1'b0;
        nd = cells[g];
        for (int l = 0; l < int'(LANES); l++) begin
          if (wr[l].en && (wr[l].idx == IDX_W'(g))) begin
            we = 1'b1;
            nd = wr[l].data;
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cells[g] <= '0;
        end else if (we) begin
          cells[g] <= nd;
        end
      end
    end else begin : g_hole
      assign cells[g] = '0;
    end
  end

  for (genvar l = 0; l < int'(LANES); l++) begin : g_rd
    assign rd_data[l] = (rd_idx[l] < IDX_W'(N)) ? cells[rd_idx[l]] : '0;
  end

  assign cells_flat = cells;

endmodule

// File: rtl/erf_host_front.sv
module erf_host_front
  import erf_pkg::*;
#(
  parameter int unsigned WORD_ADDR_W = 6,
  parameter int unsigned PHASE_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_little,
  input  logic                      cfg_wide,
  input  logic                      cfg_serial,
  input  logic [WORD_ADDR_W-1:0]    h_addr,
  input  logic                      h_bsel,
  input  logic                      h_wr,
  input  logic [LANES*BYTE_W-1:0]   h_wdata,
  input  logic [LANES-1:0]          h_be,
  output logic [LANES*BYTE_W-1:0]   h_rdata,
  output logic [PHASE_W-1:0]        wr_phase
);

  localparam int unsigned BA_W = WORD_ADDR_W + 1;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  logic slot;
  logic wide_eff;

  erf_phase_pacer #(.W(PHASE_W)) u_pacer (
    .clk   (clk),
    .rst_n (rst_q_n),
    .phase (wr_phase),
    .slot  (slot)
  );

  // Serial host always uses byte addressing
  assign wide_eff = cfg_wide & ~cfg_serial;

  logic [LANES-1:0][BA_W-1:0]   lane_ba;
  logic [LANES-1:0][IDX_W-1:0]  lane_idx;
  logic [LANES-1:0]             lane_hit;
  logic [LANES-1:0]             lane_live;
  lane_wr_t [LANES-1:0]         lane_req;
  lane_wr_t [LANES-1:0]         lane_commit;
  logic [LANES-1:0][BYTE_W-1:0] rd_bytes;
  logic [MAP_BYTES*BYTE_W-1:0]  cells_flat;
  logic                         pend_busy;

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    logic lane_pick;
    logic lane_en;
    // Upper lane carries the higher byte address in little-endian order
    assign lane_pick    = (l == int'(LANES) - 1) ? cfg_little : ~cfg_little;
    assign lane_ba[l]   = wide_eff ? {h_addr, lane_pick} : {h_addr, h_bsel};
    assign lane_live[l] = (l == 0) ? 1'b1 : wide_eff;

    erf_addr_xlate #(.BA_W(BA_W)) u_xlate (
      .byte_addr (lane_ba[l]),
      .little    (cfg_little),
      .idx       (lane_idx[l]),
      .hit       (lane_hit[l])
    );

    assign lane_en     = lane_live[l] & lane_hit[l] & (wide_eff ? h_be[l] : 1'b1);
    assign lane_req[l] = {lane_en, lane_idx[l], h_wdata[l*BYTE_W +: BYTE_W]};
    assign h_rdata[l*BYTE_W +: BYTE_W] =
      (lane_live[l] & lane_hit[l]) ? rd_bytes[l] : '0;
  end

  erf_write_hold u_hold (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .slot         (slot),
    .req          (h_wr),
    .req_lanes    (lane_req),
    .commit_lanes (lane_commit),
    .pend_busy    (pend_busy)
  );

  erf_byte_store #(.N(MAP_BYTES)) u_store (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .wr         (lane_commit),
    .rd_idx     (lane_idx),
    .rd_data    (rd_bytes),
    .cells_flat (cells_flat)
  );

endmodule

// File: rtl/erf_host_front_checker.sv
module erf_host_front_checker #(
  parameter int unsigned PHASE_W = 3,
  parameter int unsigned CELLS_W = 192,
  parameter int unsigned UPPER_W = 8
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [PHASE_W-1:0] wr_phase,
  input logic               cfg_wide,
  input logic               cfg_serial,
  input logic [UPPER_W-1:0] rd_upper,
  input logic               pend_busy,
  input logic [CELLS_W-1:0] cells_flat
);

  // R1: one bit of the phase changes on every clock after reset
  assert_gray_step_R1: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    rst_q_n |=> ($countones(wr_phase ^ $past(wr_phase)) == 1)
  );

  // R2: the array only changes at the edge closing the 000 slot
  assert_commit_slot_R2: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    !$stable(cells_flat) |-> ($past(wr_phase) == '0)
  );

  // R3: nothing is left pending once the slot has passed
  assert_pend_clear_R3: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (wr_phase == PHASE_W'(1)) |-> !pend_busy
  );

  // R9 / R11: byte addressing leaves the upper data byte at zero
  assert_serial_narrow_R9: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (!cfg_wide || cfg_serial) |-> (rd_upper == '0)
  );

endmodule

bind erf_host_front erf_host_front_checker #(
  .PHASE_W (PHASE_W),
  .CELLS_W (erf_pkg::MAP_BYTES * erf_pkg::BYTE_W),
  .UPPER_W (erf_pkg::BYTE_W)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .wr_phase   (wr_phase),
  .cfg_wide   (cfg_wide),
  .cfg_serial (cfg_serial),
  .rd_upper   (h_rdata[2*erf_pkg::BYTE_W-1:erf_pkg::BYTE_W]),
  .pend_busy  (pend_busy),
  .cells_flat (cells_flat)
);

// File: tb/erf_host_front_bench.sv
module erf_host_front_bench;

  localparam logic [2:0] M_BE8  = 3'b000;  // {serial, wide, little}
  localparam logic [2:0] M_LE8  = 3'b001;
  localparam logic [2:0] M_BE16 = 3'b010;
  localparam logic [2:0] M_LE16 = 3'b011;
  localparam logic [2:0] M_SER  = 3'b110;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [23:0] tag;
    logic        do_wr;
    logic [2:0]  wm;
    logic [6:0]  wa;
    logic [15:0] wd;
    logic [1:0]  wbe;
    logic [2:0]  rm;
    logic [6:0]  ra;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{"R11", 1'b1, M_BE8,  7'h00, 16'h00A1, 2'b01, M_LE8,  7'h03, 16'h00A1},
    '{"R5",  1'b1, M_LE8,  7'h02, 16'h00B2, 2'b01, M_BE16, 7'h00, 16'hA1B2},
    '{"R7",  1'b1, M_BE16, 7'h02, 16'hC3D4, 2'b11, M_LE8,  7'h00, 16'h00D4},
    '{"R10", 1'b1, M_BE8,  7'h02, 16'h00EE, 2'b01, M_BE8,  7'h02, 16'h0000},
    '{"R6",  1'b1, M_BE8,  7'h10, 16'h0044, 2'b01, M_LE8,  7'h17, 16'h0044},
    '{"R6",  1'b1, M_LE8,  7'h10, 16'h0040, 2'b01, M_BE8,  7'h14, 16'h0040},
    '{"R7",  1'b1, M_LE8,  7'h13, 16'h0043, 2'b01, M_LE16, 7'h12, 16'h4300},
    '{"R8",  1'b1, M_BE16, 7'h16, 16'h5152, 2'b11, M_LE16, 7'h14, 16'h5152},
    '{"R8",  1'b1, M_LE16, 7'h14, 16'h6162, 2'b10, M_BE8,  7'h16, 16'h0061},
    '{"R8",  1'b0, M_BE8,  7'h00, 16'h0000, 2'b00, M_BE8,  7'h17, 16'h0052},
    '{"R9",  1'b1, M_SER,  7'h05, 16'h0077, 2'b00, M_SER,  7'h05, 16'h0077},
    '{"R10", 1'b1, M_LE8,  7'h0F, 16'h0099, 2'b01, M_LE8,  7'h0F, 16'h0000},
    '{"R10", 1'b1, M_BE8,  7'h18, 16'h005A, 2'b01, M_BE8,  7'h18, 16'h0000},
    '{"R7",  1'b1, M_BE16, 7'h0E, 16'hABCD, 2'b11, M_LE16, 7'h0C, 16'hABCD},
    '{"R5",  1'b0, M_BE8,  7'h00, 16'h0000, 2'b00, M_LE8,  7'h0C, 16'h00CD}
  };

  localparam logic [2:0] GSEQ [8] = '{3'b000, 3'b001, 3'b011, 3'b010,
                                      3'b110, 3'b111, 3'b101, 3'b100};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_little = 1'b0, cfg_wide = 1'b0, cfg_serial = 1'b0;
  logic [5:0]  h_addr = '0;
  logic        h_bsel = 1'b0;
  logic        h_wr = 1'b0;
  logic [15:0] h_wdata = '0;
  logic [1:0]  h_be = '0;
  logic [15:0] h_rdata;
  logic [2:0]  wr_phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  erf_host_front u_erf_host_front (
    .clk(clk), .rst_n(rst_n), .cfg_little(cfg_little), .cfg_wide(cfg_wide),
    .cfg_serial(cfg_serial), .h_addr(h_addr), .h_bsel(h_bsel), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_be(h_be), .h_rdata(h_rdata), .wr_phase(wr_phase)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input logic [23:0] tag, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    {cfg_serial, cfg_wide, cfg_little} = m;
  endtask

  task automatic set_addr(input logic [6:0] ba);
    h_addr = ba[6:1];
    h_bsel = ba[0];
  endtask

  task automatic wait_slot();
    @(negedge clk);
    while (wr_phase !== 3'b000) @(negedge clk);
  endtask

  task automatic paced_write(input logic [2:0] m, input logic [6:0] ba,
                             input logic [15:0] d, input logic [1:0] be);
    wait_slot();
    set_mode(m);
    set_addr(ba);
    h_wdata = d;
    h_be    = be;
    h_wr    = 1'b1;
    @(negedge clk);
    h_wr    = 1'b0;
  endtask

  task automatic read_at(input logic [2:0] m, input logic [6:0] ba, output logic [15:0] v);
    set_mode(m);
    set_addr(ba);
    #2;
    v = h_rdata;
  endtask

  initial begin
    logic [15:0] v;
    logic [2:0]  prev;
    logic [2:0]  want;
    logic        gray_bad;

    // Reset state (R1)
    repeat (3) @(negedge clk);
    read_at(M_BE8, 7'h00, v);
    check("R1", v, 16'h0000);
    check("R1", {13'd0, wr_phase}, 16'h0000);
    rst_n = 1'b1;

    // Gray sequence (R1)
    repeat (4) @(negedge clk);
    gray_bad = 1'b0;
    prev = wr_phase;
    want = '0;
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (GSEQ[k] == prev) want = GSEQ[(k + 1) % 8];
      end
      @(negedge clk);
      if (wr_phase !== want && !gray_bad) begin
        gray_bad = 1'b1;
        $display("FAIL R1 gray step: actual=%b expected=%b", wr_phase, want);
      end
      prev = wr_phase;
    end
    checks = checks + 1;
    if (gray_bad) errors = errors + 1;

    // Vector table: write through one addressing mode, read through another
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].do_wr) begin
        paced_write(VECS[i].wm, VECS[i].wa, VECS[i].wd, VECS[i].wbe);
      end else begin
        @(negedge clk);
      end
      read_at(VECS[i].rm, VECS[i].ra, v);
      check(VECS[i].tag, v, VECS[i].exp);
    end

    // Pending replacement outside the slot (R2, R3)
    wait_slot();
    @(negedge clk);                // phase 001
    set_mode(M_BE8); set_addr(7'h08); h_wdata = 16'h0011; h_wr = 1'b1;
    @(negedge clk);                // phase 011
    set_addr(7'h09); h_wdata = 16'h0022;
    @(negedge clk);
    h_wr = 1'b0;
    read_at(M_BE8, 7'h09, v);
    check("R2", v, 16'h0000);
    read_at(M_BE8, 7'h08, v);
    check("R2", v, 16'h0000);
    wait_slot();
    @(negedge clk);
    read_at(M_BE8, 7'h09, v);
    check("R3", v, 16'h0022);
    read_at(M_BE8, 7'h08, v);
    check("R3", v, 16'h0000);

    // Strobe held for eight clocks from a non-slot phase (R4)
    @(negedge clk);
    while (wr_phase !== 3'b010) @(negedge clk);
    set_mode(M_BE8); set_addr(7'h0A); h_wdata = 16'h0033; h_wr = 1'b1;
    repeat (8) @(negedge clk);
    h_wr = 1'b0;
    read_at(M_BE8, 7'h0A, v);
    check("R4", v, 16'h0033);

    // Reset clears the array again (R1)
    wait_slot();
    @(negedge clk);
    rst_n = 1'b0;
    read_at(M_LE8, 7'h03, v);
    check("R1", v, 16'h0000);
    check("R1", {13'd0, wr_phase}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule